// File: doc/BRIEF.md
# Serial Receiver Status Flag Unit

This block keeps the receive-side status flags of an asynchronous serial port and the receive data register. A receiver core, which is not part of the block, sends it single-cycle event pulses. A word-complete pulse carries the received byte and three qualifiers: noise seen, framing or break seen, and parity bad. A separate pulse reports an idle line. The block folds these events into six sticky flags, holds the last accepted byte and drives one level-sensitive interrupt request. The request is gated by three enables: idle, receive and parity.

Software clears the flags in two steps. It first accesses the status register and then reads the data register. The status access records which flags are set at that moment. The data read that follows clears only the recorded flags. A flag that is raised between the two accesses therefore survives. Two small state machines carry the ordering. The clear sequencer has the states `SEQ_IDLE` and `SEQ_ARMED`. A status access moves it from `SEQ_IDLE` to `SEQ_ARMED`, and another status access in `SEQ_ARMED` refreshes the snapshot. A data read moves it from `SEQ_ARMED` back to `SEQ_IDLE`. The idle gate has the states `IDL_ARMED` and `IDL_LOCKED`. An idle event in `IDL_ARMED` raises the idle flag and moves the gate to `IDL_LOCKED`. A word loaded into the data register moves it back to `IDL_ARMED`.

Top module: `rx_status_unit`

## Requirements
- R1: After reset, the status byte, the data register and the interrupt request are all 0, the clear sequencer is in `SEQ_IDLE` and the idle gate is in `IDL_ARMED`.
- R2: Status bit positions: bit 5 data-full, bit 4 idle, bit 3 overrun, bit 2 noise, bit 1 framing, bit 0 parity. Bits 7:6 read 0. A word pulse that arrives while data-full is clear loads the byte, sets data-full and copies the noise, framing and parity qualifiers into bits 2, 1 and 0. All of this is visible on the cycle after the pulse.
- R3: A data read that follows a status access clears every flag that was set at the time of that access. A data read with no pending status access changes no flag.
- R4: A flag raised after the status access and before the data read stays set after the read.
- R5: An idle pulse sets bit 4 only while the idle gate is in `IDL_ARMED`. Once bit 4 has been set, further idle pulses have no effect until a word has been loaded into the data register.
- R6: A word pulse that arrives while data-full is still set (after any clear taking effect in the same cycle) sets overrun. The data register keeps its old byte, and that word's noise, framing and parity qualifiers are discarded.
- R7: The interrupt request is 1 exactly when (idle and idle enable) or ((data-full or overrun) and receive enable) or (parity and parity enable). Noise and framing never raise it by themselves.
- R8: When a clear and a new set hit the same flag in the same cycle, the set wins. In particular, a word that arrives together with a read that clears data-full is loaded as a normal word, not as an overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_word_i | input | 1 | Word-complete pulse from the receiver core |
| rx_byte_i | input | DATA_W | Received byte, valid with rx_word_i |
| rx_idle_i | input | 1 | Idle-line detected pulse |
| rx_noise_i | input | 1 | Noise qualifier for the word pulse |
| rx_frame_i | input | 1 | Framing/break qualifier for the word pulse |
| rx_parity_i | input | 1 | Parity-bad qualifier for the word pulse |
| cpu_stat_acc_i | input | 1 | Status register access strobe |
| cpu_data_rd_i | input | 1 | Data register read strobe |
| ie_idle_i | input | 1 | Idle interrupt enable |
| ie_rx_i | input | 1 | Receive (data-full/overrun) interrupt enable |
| ie_par_i | input | 1 | Parity interrupt enable |
| status_o | output | STAT_W | Status byte |
| rx_data_o | output | DATA_W | Receive data register |
| irq_o | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check several rules. A lone data read never drops a flag. An overrun leaves the data register untouched and suppresses the framing flag. A locked idle gate never lets bit 4 rise. The request is low when only noise or framing is set, and high when data-full is set with the receive enable on. Other behaviour can only be shown by the bench's scenarios. These are the snapshot semantics of the two-step clear (which flags survive), the exact byte captured, the re-arming of idle after a new word, and the same-cycle race between a clearing read and a new word. The bench compares those cycle by cycle against a model built from the requirements, under directed cases and seeded random traffic.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

    localparam int FLAG_N = 6;
    localparam int B_PE   = 0;
    localparam int B_FE   = 1;
    localparam int B_NF   = 2;
    localparam int B_OR   = 3;
    localparam int B_IDLE = 4;
    localparam int B_FULL = 5;

    typedef logic [FLAG_N-1:0] flags_t;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_ARMED = 1'b1
    } seq_state_t;

    typedef enum logic {
        IDL_ARMED  = 1'b0,
        IDL_LOCKED = 1'b1
    } idl_state_t;

endpackage

// File: rtl/rxs_clear_seq.sv
module rxs_clear_seq
    import rxs_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   stat_acc,
    input  logic   data_rd,
    input  flags_t flags,
    output flags_t clr_mask,
    output logic   armed
);

    seq_state_t state_q, state_d;
    flags_t     snap_q;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: begin
                if (stat_acc) state_d = SEQ_ARMED;
            end
            SEQ_ARMED: begin
                if (stat_acc)     state_d = SEQ_ARMED;
                else if (data_rd) state_d = SEQ_IDLE;
            end
        endcase
    end

    // state and snapshot registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            snap_q  <= '0;
        end else begin
            state_q <= state_d;
            if (stat_acc) snap_q <= flags;
        end
    end

    // outputs
    always_comb begin
        armed    = (state_q == SEQ_ARMED);
        clr_mask = (armed && data_rd) ? snap_q : '0;
    end

endmodule

// File: rtl/rxs_idle_gate.sv
module rxs_idle_gate
    import rxs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic idle_ev,
    input  logic word_load,
    output logic idle_set,
    output logic locked
);

    idl_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IDL_ARMED: begin
                if (idle_ev && !word_load) state_d = IDL_LOCKED;
            end
            IDL_LOCKED: begin
                if (word_load) state_d = IDL_ARMED;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IDL_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        locked   = (state_q == IDL_LOCKED);
        idle_set = idle_ev && (state_q == IDL_ARMED);
    end

endmodule

// File: rtl/rxs_flag_bank.sv
module rxs_flag_bank
    import rxs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_ev,
    input  logic [DATA_W-1:0] word_data,
    input  logic              q_noise,
    input  logic              q_frame,
    input  logic              q_parity,
    input  logic              idle_set,
    input  flags_t            clr_mask,
    output flags_t            flags,
    output logic [DATA_W-1:0] rx_data,
    output logic              word_load
);

    flags_t flags_q, set_vec;
    logic   full_eff, overrun;
    logic [DATA_W-1:0] data_q;

    always_comb begin
        full_eff  = flags_q[B_FULL] & ~clr_mask[B_FULL];
        word_load = word_ev & ~full_eff;
        overrun   = word_ev & full_eff;
        set_vec          = '0;
        set_vec[B_FULL]  = word_load;
        set_vec[B_IDLE]  = idle_set;
        set_vec[B_OR]    = overrun;
        set_vec[B_NF]    = word_load & q_noise;
        set_vec[B_FE]    = word_load & q_frame;
        set_vec[B_PE]    = word_load & q_parity;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
            data_q  <= '0;
        end else begin
            flags_q <= (flags_q & ~clr_mask) | set_vec;
            if (word_load) data_q <= word_data;
        end
    end

    assign flags   = flags_q;
    assign rx_data = data_q;

endmodule

// File: rtl/rxs_irq_gen.sv
module rxs_irq_gen (
    input  logic f_idle,
    input  logic f_full,
    input  logic f_over,
    input  logic f_par,
    input  logic en_idle,
    input  logic en_rx,
    input  logic en_par,
    output logic irq
);

    always_comb begin
        irq = (f_idle & en_idle) | ((f_full | f_over) & en_rx) | (f_par & en_par);
    end

endmodule

// File: rtl/rx_status_unit.sv
module rx_status_unit
    import rxs_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_word_i,
    input  logic [DATA_W-1:0] rx_byte_i,
    input  logic              rx_idle_i,
    input  logic              rx_noise_i,
    input  logic              rx_frame_i,
    input  logic              rx_parity_i,
    input  logic              cpu_stat_acc_i,
    input  logic              cpu_data_rd_i,
    input  logic              ie_idle_i,
    input  logic              ie_rx_i,
    input  logic              ie_par_i,
    output logic [STAT_W-1:0] status_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              irq_o
);

    localparam int PAD_W = STAT_W - FLAG_N;

    flags_t flags, clr_mask;
    logic   seq_armed, idle_locked, idle_set, word_load;

    rxs_clear_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .stat_acc (cpu_stat_acc_i),
        .data_rd  (cpu_data_rd_i),
        .flags    (flags),
        .clr_mask (clr_mask),
        .armed    (seq_armed)
    );

    rxs_idle_gate u_idle (
        .clk       (clk),
        .rst_n     (rst_n),
        .idle_ev   (rx_idle_i),
        .word_load (word_load),
        .idle_set  (idle_set),
        .locked    (idle_locked)
    );

    rxs_flag_bank #(.DATA_W(DATA_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_ev   (rx_word_i),
        .word_data (rx_byte_i),
        .q_noise   (rx_noise_i),
        .q_frame   (rx_frame_i),
        .q_parity  (rx_parity_i),
        .idle_set  (idle_set),
        .clr_mask  (clr_mask),
        .flags     (flags),
        .rx_data   (rx_data_o),
        .word_load (word_load)
    );

    rxs_irq_gen u_irq (
        .f_idle  (flags[B_IDLE]),
        .f_full  (flags[B_FULL]),
        .f_over  (flags[B_OR]),
        .f_par   (flags[B_PE]),
        .en_idle (ie_idle_i),
        .en_rx   (ie_rx_i),
        .en_par  (ie_par_i),
        .irq     (irq_o)
    );

    generate
        if (PAD_W > 0) begin : g_pad
            assign status_o = {{PAD_W{1'b0}}, flags};
        end else begin : g_nopad
            assign status_o = flags[STAT_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/rxs_status_checker.sv
module rxs_status_checker #(
    parameter int DATA_W = 8,
    parameter int STAT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ev_word,
    input logic              ev_idle,
    input logic              stat_acc,
    input logic              data_rd,
    input logic              en_rx,
    input logic [STAT_W-1:0] status,
    input logic [DATA_W-1:0] rx_data,
    input logic              irq,
    input logic              seq_armed,
    input logic              idle_locked
);

    // R3: a data read without a pending status access drops no flag
    p_lone_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !seq_armed && !stat_acc) |=> (($past(status) & ~status) == '0));

    // R6: overrun keeps the stored byte and sets bit 3
    p_overrun_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_word && status[5] && !data_rd) |=> ($stable(rx_data) && status[3]));

    // R6: the overrunning word does not touch the framing flag
    p_overrun_nofe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_word && status[5] && !data_rd) |=> $stable(status[1]));

    // R5: a locked idle gate never lets the idle flag rise
    p_idle_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_idle && idle_locked) |=> !$rose(status[4]));

    // R7: noise and framing alone never request an interrupt
    p_quiet_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (status[5:3] == 3'b000 && !status[0]) |-> !irq);

    // R7: data-full with receive enable always requests
    p_full_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_rx && status[5]) |-> irq);

endmodule

bind rx_status_unit rxs_status_checker #(.DATA_W(DATA_W), .STAT_W(STAT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_word     (rx_word_i),
    .ev_idle     (rx_idle_i),
    .stat_acc    (cpu_stat_acc_i),
    .data_rd     (cpu_data_rd_i),
    .en_rx       (ie_rx_i),
    .status      (status_o),
    .rx_data     (rx_data_o),
    .irq         (irq_o),
    .seq_armed   (seq_armed),
    .idle_locked (idle_locked)
);

// File: tb/rx_status_unit_test.sv
module rx_status_unit_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       w = 0, idl = 0, nz = 0, fr = 0, pa = 0, sa = 0, rd = 0;
    logic [7:0] d = '0;
    logic       ei = 0, er = 0, ep = 0;
    logic [7:0] status;
    logic [7:0] rdata;
    logic       irq;

    int total = 0;
    int bad   = 0;

    // requirement-based model
    logic [5:0] m_flags = '0, m_snap = '0;
    logic [7:0] m_data = '0;
    logic       m_armed = 0, m_idle_ok = 1;

    always #2 clk = ~clk;

    rx_status_unit uut (
        .clk(clk), .rst_n(rst_n), .rx_word_i(w), .rx_byte_i(d), .rx_idle_i(idl),
        .rx_noise_i(nz), .rx_frame_i(fr), .rx_parity_i(pa),
        .cpu_stat_acc_i(sa), .cpu_data_rd_i(rd),
        .ie_idle_i(ei), .ie_rx_i(er), .ie_par_i(ep),
        .status_o(status), .rx_data_o(rdata), .irq_o(irq)
    );

    function automatic logic exp_irq(logic [5:0] f, logic a, logic b, logic c);
        return (f[4] & a) | ((f[5] | f[3]) & b) | (f[0] & c);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic model_update();
        logic [5:0] clr, setv;
        logic full, ld, ov, iset;
        clr  = (m_armed && rd) ? m_snap : 6'd0;
        full = m_flags[5] & ~clr[5];
        ld   = w & ~full;
        ov   = w & full;
        iset = idl & m_idle_ok;
        setv = {ld, iset, ov, ld & nz, ld & fr, ld & pa};
        if (sa) begin
            m_snap  = m_flags;
            m_armed = 1'b1;
        end else if (rd && m_armed) begin
            m_armed = 1'b0;
        end
        if (ld)        m_idle_ok = 1'b1;
        else if (iset) m_idle_ok = 1'b0;
        if (ld) m_data = d;
        m_flags = (m_flags & ~clr) | setv;
    endtask

    // drive at negedge, step one edge, compare at the next negedge
    task automatic step(string tag);
        @(posedge clk);
        model_update();
        @(negedge clk);
        chk({tag, " status"}, {24'd0, status}, {26'd0, m_flags});
        chk({tag, " data"},   {24'd0, rdata},  {24'd0, m_data});
        chk({tag, " irq"},    {31'd0, irq},    {31'd0, exp_irq(m_flags, ei, er, ep)});
        w = 0; idl = 0; nz = 0; fr = 0; pa = 0; sa = 0; rd = 0;
    endtask

    task automatic clear_all(string tag);
        sa = 1; step(tag);
        rd = 1; step(tag);
    endtask

    initial begin
        #(4 * 200000);
        bad++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1 status", {24'd0, status}, 32'd0);
        chk("R1 data",   {24'd0, rdata},  32'd0);
        chk("R1 irq",    {31'd0, irq},    32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: word with noise lands in bit 5 and bit 2
        w = 1; d = 8'hA5; nz = 1; step("R2");
        chk("R2 layout", {24'd0, status}, 32'h24);
        chk("R2 byte",   {24'd0, rdata},  32'hA5);

        // R3: read alone clears nothing, then full sequence clears all
        rd = 1; step("R3");
        chk("R3 lone read", {24'd0, status}, 32'h24);
        clear_all("R3");
        chk("R3 cleared", {24'd0, status}, 32'h00);

        // R4: idle raised between access and read survives
        w = 1; d = 8'h11; step("R4");
        sa = 1; step("R4");
        idl = 1; step("R4");
        rd = 1; step("R4");
        chk("R4 survivor", {24'd0, status}, 32'h10);

        // R5: idle locked until a new word
        clear_all("R5");
        idl = 1; step("R5");
        chk("R5 locked", {24'd0, status}, 32'h00);
        w = 1; d = 8'h22; step("R5");
        idl = 1; step("R5");
        chk("R5 rearmed", {24'd0, status}, 32'h30);

        // R6: overrun keeps byte and masks framing; R7 irq with receive enable
        er = 1;
        w = 1; d = 8'h33; fr = 1; step("R6");
        chk("R6 flags", {24'd0, status}, 32'h38);
        chk("R6 byte",  {24'd0, rdata},  32'h22);
        chk("R7 rx irq", {31'd0, irq}, 32'd1);
        clear_all("R6");
        chk("R7 irq low", {31'd0, irq}, 32'd0);

        // R7: noise and framing alone, receive enable off
        er = 0; ei = 1; ep = 1;
        w = 1; d = 8'h5A; nz = 1; fr = 1; step("R7");
        chk("R7 quiet", {31'd0, irq}, 32'd0);
        clear_all("R7");
        w = 1; d = 8'h5B; pa = 1; step("R7");
        chk("R7 parity irq", {31'd0, irq}, 32'd1);
        clear_all("R7");

        // R8: clearing read races a new word
        w = 1; d = 8'h44; step("R8");
        sa = 1; step("R8");
        rd = 1; w = 1; d = 8'h55; step("R8");
        chk("R8 status", {24'd0, status}, 32'h20);
        chk("R8 byte",   {24'd0, rdata},  32'h55);
        clear_all("R8");

        // random traffic checked against the model (R2..R8)
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] cpu;
            w   = ($urandom % 5) == 0;
            d   = 8'($urandom);
            nz  = ($urandom % 3) == 0;
            fr  = ($urandom % 3) == 0;
            pa  = ($urandom % 3) == 0;
            idl = ($urandom % 6) == 0;
            cpu = 4'($urandom);
            sa  = (cpu < 4'd3);
            rd  = (cpu >= 4'd3) && (cpu < 4'd7);
            if ((i % 64) == 0) begin
                ei = 1'($urandom); er = 1'($urandom); ep = 1'($urandom);
            end
            step("R3 R6 R8 random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule